// File: doc/BRIEF.md
# Low-Power Controller Configuration Register Block

This block holds the configuration that a low-power sequencer needs: a low-power hint, five domain option bits, a wakeup-source enable mask and a reset-source enable mask. Software reaches all of it through a simple word-addressed read/write port on the fast bus clock. The sequencer runs from a slow always-on clock and sees only registered copies in its own domain.

Configuration writes stay staged in the fast domain. They move to the slow domain only when software sets the sync bit. That starts a toggle request/acknowledge handshake through multi-flop synchronizers. The fast side snapshots the staged values when the transfer starts. The snapshot holds still until the slow side has sampled it and the acknowledge has returned. The control register locks itself once the core signals wait-for-interrupt while the hint is set, and unlocks when the controller reports a return to active power. Each enable mask has its own sticky write-enable. Live wakeup and reset request lines can be read back through two status words.

Word map (word addresses): 0 control, 1 control write-enable status, 2 wakeup enable, 3 wakeup write-enable, 4 reset enable, 5 reset write-enable, 6 sync, 7 wakeup status, 8 reset status. Unmapped addresses read 0.

Top module: `pmc_cfg_regs`

## Requirements
- R1: After reset, control, wakeup enable, reset enable, sync and both status-free registers read 0. The control write-enable status, wakeup write-enable and reset write-enable read 1. All slow-domain outputs are 0.
- R2: In the control word, bit 0 is the low-power hint. Bits 4 to 8 are the domain options, in this order: core clock kept in low power (bit 4), IO clock kept in low power, USB clock kept in low power, USB clock kept in active power, and main power kept on in low power (bit 8). All other bits read 0.
- R3: If the stored hint is 1 at a rising edge where the wait-for-interrupt input is high, the control register locks. From the next cycle it ignores writes and its write-enable status (address 1, bit 0) reads 0. With the hint at 0, wait-for-interrupt causes no lock.
- R4: A cycle with the active-power input high unlocks the control register, unless the lock condition of R3 holds in that same cycle. In that case the lock wins.
- R5: Wakeup enable keeps bits 4:0 and reset enable keeps bit 0. Other written bits read 0.
- R6: Writing 0 to bit 0 of a write-enable word clears it. After that, writes to the enable register it guards are ignored. Writing 1 does not set it again; only reset does. Each write-enable guards only its own register.
- R7: Writes to control, wakeup enable or reset enable do not change the slow-domain outputs until a sync is performed.
- R8: Writing 1 to bit 0 of the sync word starts a transfer. The sync bit reads 1 from the next cycle and returns to 0 by itself. Once it reads 0, the slow outputs show the values that were staged in the cycle the sync was written.
- R9: While a transfer is in flight, further sync writes are ignored and staged writes do not alter the values being transferred.
- R10: The status words show the live wakeup request lines in bits 4:0 and the reset request line in bit 0, the same positions as the enable masks.
- R11: A control write in the very cycle that the R3 lock condition arises is still accepted. The lock applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Fast-domain reset, active low |
| aon_clk_i | input | 1 | Slow always-on clock |
| aon_rst_ni | input | 1 | Slow-domain reset, active low |
| reg_addr_i | input | ADDR_W | Word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, combinational on address |
| wfi_i | input | 1 | Core wait-for-interrupt indication |
| active_i | input | 1 | Controller back in active power state |
| wake_req_i | input | N_WAKE | Live wakeup request lines |
| rst_req_i | input | N_RST | Live reset request lines |
| aon_hint_o | output | 1 | Slow copy of the low-power hint |
| aon_opts_o | output | 5 | Slow copy of the domain options |
| aon_wake_en_o | output | N_WAKE | Slow copy of the wakeup enable mask |
| aon_rst_en_o | output | N_RST | Slow copy of the reset enable mask |

## Verification
Two kinds of event can land in the same cycle. The first is a control write that arrives in the very edge where wait-for-interrupt meets a set hint. The bench drives both on one edge and expects the written value to stick while the write-enable status drops, and it expects a later write to bounce off. The second is a staged write or a second sync that arrives while a transfer is still in flight. The bench issues both right after starting a sync and judges by the slow outputs. Those outputs must carry the first snapshot, must not change afterwards, and pick up the new value only after a fresh sync. A third case drives the lock and unlock inputs together, and the lock must win.

// File: rtl/pmc_cfg_pkg.sv
package pmc_cfg_pkg;
   localparam int unsigned N_OPTS = 5;

   // option order inside the control word, from the base bit upward
   localparam int unsigned OPT_CORE_CLK_LP = 0;
   localparam int unsigned OPT_IO_CLK_LP   = 1;
   localparam int unsigned OPT_USB_CLK_LP  = 2;
   localparam int unsigned OPT_USB_CLK_ACT = 3;
   localparam int unsigned OPT_MAIN_PWR_LP = 4;

   // word addresses
   localparam int unsigned A_CTRL      = 0;
   localparam int unsigned A_CTRL_WEN  = 1;
   localparam int unsigned A_WAKE_EN   = 2;
   localparam int unsigned A_WAKE_WEN  = 3;
   localparam int unsigned A_RST_EN    = 4;
   localparam int unsigned A_RST_WEN   = 5;
   localparam int unsigned A_SYNC      = 6;
   localparam int unsigned A_WAKE_STAT = 7;
   localparam int unsigned A_RST_STAT  = 8;
   localparam int unsigned MIN_ADDR_W  = 4;
endpackage

// File: rtl/pmc_sync_ff.sv
module pmc_sync_ff #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmc_sync_ff: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= d_i;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pmc_sticky_wen.sv
module pmc_sticky_wen (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic wen_o
);
   logic wen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    wen_q <= 1'b1;
      else if (clr_i) wen_q <= 1'b0;
   end

   assign wen_o = wen_q;

   // R6: a cleared write-enable never returns without reset
   p_wen_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wen_q |=> !wen_q);
endmodule

// File: rtl/pmc_guarded_reg.sv
module pmc_guarded_reg #(
   parameter int unsigned W = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic         wen_i,
   input  logic [W-1:0] wd_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] val_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             val_q <= '0;
      else if (we_i && wen_i)  val_q <= wd_i;
   end

   assign q_o = val_q;

   // R3 / R6: a write refused by the guard leaves the value untouched
   p_guard_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !wen_i) |=> $stable(val_q));
endmodule

// File: rtl/pmc_cdc_xfer.sv
module pmc_cdc_xfer #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_f_i,
   input  logic         rst_f_ni,
   input  logic         clk_s_i,
   input  logic         rst_s_ni,
   input  logic         start_i,
   input  logic [W-1:0] data_i,
   output logic         busy_o,
   output logic [W-1:0] data_o
);
   logic         req_q;
   logic [W-1:0] snap_q;
   logic         ack_f;
   logic         req_s;
   logic         seen_q;
   logic [W-1:0] out_q;
   logic         accept;

   assign busy_o = req_q ^ ack_f;
   assign accept = start_i && !busy_o;

   // fast side: snapshot and toggle the request
   always_ff @(posedge clk_f_i or negedge rst_f_ni) begin
      if (!rst_f_ni) begin
         req_q  <= 1'b0;
         snap_q <= '0;
      end else if (accept) begin
         req_q  <= ~req_q;
         snap_q <= data_i;
      end
   end

   pmc_sync_ff #(.W(1), .STAGES(STAGES)) u_req_sync (
      .clk_i (clk_s_i),
      .rst_ni(rst_s_ni),
      .d_i   (req_q),
      .q_o   (req_s)
   );

   // slow side: load on each request edge, echo back as acknowledge
   always_ff @(posedge clk_s_i or negedge rst_s_ni) begin
      if (!rst_s_ni) begin
         seen_q <= 1'b0;
         out_q  <= '0;
      end else if (req_s != seen_q) begin
         seen_q <= req_s;
         out_q  <= snap_q;
      end
   end

   pmc_sync_ff #(.W(1), .STAGES(STAGES)) u_ack_sync (
      .clk_i (clk_f_i),
      .rst_ni(rst_f_ni),
      .d_i   (seen_q),
      .q_o   (ack_f)
   );

   assign data_o = out_q;

   // R9: snapshot frozen while a transfer is in flight
   p_snap_hold_r9: assert property (@(posedge clk_f_i) disable iff (!rst_f_ni)
      busy_o |=> $stable(snap_q));
   // R9: a sync request during a transfer does not toggle the request
   p_busy_ignores_start_r9: assert property (@(posedge clk_f_i) disable iff (!rst_f_ni)
      (start_i && busy_o) |=> $stable(req_q));
   // R7: slow copies only move on a request edge
   p_slow_hold_r7: assert property (@(posedge clk_s_i) disable iff (!rst_s_ni)
      (req_s == seen_q) |=> $stable(out_q));
endmodule

// File: rtl/pmc_cfg_regs.sv
module pmc_cfg_regs
   import pmc_cfg_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned N_WAKE      = 5,
   parameter int unsigned N_RST       = 1,
   parameter int unsigned OPT_BASE    = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              aon_clk_i,
   input  logic              aon_rst_ni,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              wfi_i,
   input  logic              active_i,
   input  logic [N_WAKE-1:0] wake_req_i,
   input  logic [N_RST-1:0]  rst_req_i,
   output logic              aon_hint_o,
   output logic [N_OPTS-1:0] aon_opts_o,
   output logic [N_WAKE-1:0] aon_wake_en_o,
   output logic [N_RST-1:0]  aon_rst_en_o
);
   localparam int unsigned CTRL_W = 1 + N_OPTS;
   localparam int unsigned XFER_W = CTRL_W + N_WAKE + N_RST;

   if (OPT_BASE < 1 || OPT_BASE + N_OPTS > DATA_W) begin : g_bad_opt_base
      $error("pmc_cfg_regs: option field must sit above bit 0 inside the word");
   end
   if (N_WAKE < 1 || N_WAKE > DATA_W || N_RST < 1 || N_RST > DATA_W) begin : g_bad_src
      $error("pmc_cfg_regs: source counts must fit in one word");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("pmc_cfg_regs: address too narrow for the word map");
   end

   // address decode
   logic hit_ctrl, hit_wake_en, hit_wake_wen, hit_rst_en, hit_rst_wen, hit_sync;
   assign hit_ctrl     = reg_addr_i == ADDR_W'(A_CTRL);
   assign hit_wake_en  = reg_addr_i == ADDR_W'(A_WAKE_EN);
   assign hit_wake_wen = reg_addr_i == ADDR_W'(A_WAKE_WEN);
   assign hit_rst_en   = reg_addr_i == ADDR_W'(A_RST_EN);
   assign hit_rst_wen  = reg_addr_i == ADDR_W'(A_RST_WEN);
   assign hit_sync     = reg_addr_i == ADDR_W'(A_SYNC);

   // control register with automatic lock
   logic              ctrl_lock_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CTRL_W-1:0] ctrl_wd;
   logic              hint_q;
   logic [N_OPTS-1:0] opts_q;
   logic              lock_set;

   assign ctrl_wd  = {reg_wdata_i[OPT_BASE +: N_OPTS], reg_wdata_i[0]};
   assign hint_q   = ctrl_q[0];
   assign opts_q   = ctrl_q[CTRL_W-1:1];
   assign lock_set = hint_q && wfi_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ctrl_lock_q <= 1'b0;
      else if (lock_set)  ctrl_lock_q <= 1'b1;
      else if (active_i)  ctrl_lock_q <= 1'b0;
   end

   pmc_guarded_reg #(.W(CTRL_W)) u_ctrl (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (reg_we_i && hit_ctrl),
      .wen_i (!ctrl_lock_q),
      .wd_i  (ctrl_wd),
      .q_o   (ctrl_q)
   );

   // source enables, each behind its own sticky write-enable
   logic              wake_wen, rst_wen;
   logic [N_WAKE-1:0] wake_en_q;
   logic [N_RST-1:0]  rst_en_q;

   pmc_sticky_wen u_wake_wen (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (reg_we_i && hit_wake_wen && !reg_wdata_i[0]),
      .wen_o (wake_wen)
   );

   pmc_sticky_wen u_rst_wen (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (reg_we_i && hit_rst_wen && !reg_wdata_i[0]),
      .wen_o (rst_wen)
   );

   pmc_guarded_reg #(.W(N_WAKE)) u_wake_en (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (reg_we_i && hit_wake_en),
      .wen_i (wake_wen),
      .wd_i  (reg_wdata_i[N_WAKE-1:0]),
      .q_o   (wake_en_q)
   );

   pmc_guarded_reg #(.W(N_RST)) u_rst_en (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (reg_we_i && hit_rst_en),
      .wen_i (rst_wen),
      .wd_i  (reg_wdata_i[N_RST-1:0]),
      .q_o   (rst_en_q)
   );

   // cross-domain transfer
   logic              sync_busy;
   logic [XFER_W-1:0] aon_bundle;

   pmc_cdc_xfer #(.W(XFER_W), .STAGES(SYNC_STAGES)) u_xfer (
      .clk_f_i (clk_i),
      .rst_f_ni(rst_ni),
      .clk_s_i (aon_clk_i),
      .rst_s_ni(aon_rst_ni),
      .start_i (reg_we_i && hit_sync && reg_wdata_i[0]),
      .data_i  ({ctrl_q, wake_en_q, rst_en_q}),
      .busy_o  (sync_busy),
      .data_o  (aon_bundle)
   );

   assign {aon_opts_o, aon_hint_o, aon_wake_en_o, aon_rst_en_o} = aon_bundle;

   // read mux
   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(A_CTRL): begin
            reg_rdata_o[0]                 = hint_q;
            reg_rdata_o[OPT_BASE +: N_OPTS] = opts_q;
         end
         ADDR_W'(A_CTRL_WEN):  reg_rdata_o[0]        = !ctrl_lock_q;
         ADDR_W'(A_WAKE_EN):   reg_rdata_o[N_WAKE-1:0] = wake_en_q;
         ADDR_W'(A_WAKE_WEN):  reg_rdata_o[0]        = wake_wen;
         ADDR_W'(A_RST_EN):    reg_rdata_o[N_RST-1:0]  = rst_en_q;
         ADDR_W'(A_RST_WEN):   reg_rdata_o[0]        = rst_wen;
         ADDR_W'(A_SYNC):      reg_rdata_o[0]        = sync_busy;
         ADDR_W'(A_WAKE_STAT): reg_rdata_o[N_WAKE-1:0] = wake_req_i;
         ADDR_W'(A_RST_STAT):  reg_rdata_o[N_RST-1:0]  = rst_req_i;
         default:              reg_rdata_o           = '0;
      endcase
   end

   // R3 / R11: hint plus wait-for-interrupt locks from the next cycle
   p_lock_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hint_q && wfi_i) |=> ctrl_lock_q);
   // R4: active power unlocks when no lock condition competes
   p_lock_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active_i && !(hint_q && wfi_i)) |=> !ctrl_lock_q);
   // R3: a locked control word holds against writes
   p_locked_ctrl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_lock_q && reg_we_i && hit_ctrl) |=> $stable(ctrl_q));
   // R6: a cleared wakeup write-enable freezes the wakeup mask
   p_wake_guard_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wake_wen |=> $stable(wake_en_q));
endmodule

// File: tb/tb_pmc_cfg_regs.sv
module tb_pmc_cfg_regs;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0, aon_clk = 1'b0;
   logic          rst_n = 1'b0, aon_rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          wfi = 1'b0, active = 1'b0;
   logic [4:0]    wake_req = '0;
   logic [0:0]    rst_req = '0;
   logic          a_hint;
   logic [4:0]    a_opts;
   logic [4:0]    a_wake;
   logic [0:0]    a_rst;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always #23 aon_clk = ~aon_clk;

   pmc_cfg_regs dut (
      .clk_i(clk), .rst_ni(rst_n), .aon_clk_i(aon_clk), .aon_rst_ni(aon_rst_n),
      .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .wfi_i(wfi), .active_i(active), .wake_req_i(wake_req), .rst_req_i(rst_req),
      .aon_hint_o(a_hint), .aon_opts_o(a_opts), .aon_wake_en_o(a_wake),
      .aon_rst_en_o(a_rst)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic rchk(input string req, input int a, input logic [DW-1:0] exp);
      logic [DW-1:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   // start a sync, confirm busy, then wait for it to clear
   task automatic do_sync(input string req);
      logic [DW-1:0] v;
      int n;
      wr(6, 32'h1);
      rd(6, v);
      chk(req, v, 32'h1);
      n = 0;
      do begin
         @(negedge clk);
         rd(6, v);
         n++;
      end while (v[0] && n < 200);
      chk(req, v, 32'h0);
   endtask

   task automatic slow_chk(input string req, input logic h, input logic [4:0] o,
                           input logic [4:0] w, input logic r);
      chk(req, {20'h0, a_hint, a_opts, a_wake, a_rst}, {20'h0, h, o, w, r});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; aon_rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rchk("R1 ctrl", 0, 0);
      rchk("R1 ctrl_wen", 1, 1);
      rchk("R1 wake_en", 2, 0);
      rchk("R1 wake_wen", 3, 1);
      rchk("R1 rst_en", 4, 0);
      rchk("R1 rst_wen", 5, 1);
      rchk("R1 sync", 6, 0);
      slow_chk("R1 slow", 0, 0, 0, 0);

      // R2 / R8 option sweep, garbage in unused bits
      for (int k = 0; k < 32; k++) begin
         logic [DW-1:0] exp;
         exp = (DW'(k) << 4) | DW'(k & 1);
         wr(0, exp | 32'h8000_000E | (32'hFF << 9));
         rchk("R2 ctrl readback", 0, exp);
         do_sync("R8 sync");
         slow_chk("R8 slow ctrl", k[0], k[4:0], 0, 0);
      end
      // R2 order: main power only
      wr(0, 32'h100);
      do_sync("R8 sync");
      chk("R2 main power is last option", {27'h0, a_opts}, 32'h10);
      wr(0, 32'h10);
      do_sync("R8 sync");
      chk("R2 core clock is first option", {27'h0, a_opts}, 32'h01);

      // R5 wakeup mask sweep
      for (int k = 0; k < 32; k++) begin
         wr(2, DW'(k) | 32'hFFFF_FFE0);
         rchk("R5 wake_en", 2, DW'(k));
         do_sync("R8 sync");
         slow_chk("R8 slow wake", 0, 5'h01, k[4:0], 0);
      end
      wr(4, 32'hFFFF_FFFF);
      rchk("R5 rst_en", 4, 1);

      // R7 staged writes do not leak
      wr(0, 32'h1F1);
      repeat (30) @(negedge clk);
      slow_chk("R7 no leak", 0, 5'h01, 5'h1F, 0);
      do_sync("R8 sync");
      slow_chk("R8 after sync", 1, 5'h1F, 5'h1F, 1);

      // R10 status sweep
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         wake_req = k[4:0]; rst_req = k[5];
         rchk("R10 wake status", 7, DW'(k[4:0]));
         rchk("R10 rst status", 8, DW'(k[5]));
      end

      // R9 writes and sync during flight
      wr(0, 32'h0A0);
      wr(6, 32'h1);
      wr(0, 32'h050);
      wr(6, 32'h1);
      wr(2, 32'h3);
      v = 1;
      for (int n = 0; n < 200 && v[0]; n++) begin
         @(negedge clk);
         rd(6, v);
      end
      chk("R9 sync cleared", v, 0);
      slow_chk("R9 first snapshot", 0, 5'h0A, 5'h1F, 1);
      repeat (40) @(negedge clk);
      slow_chk("R9 no second transfer", 0, 5'h0A, 5'h1F, 1);
      do_sync("R8 sync");
      slow_chk("R9 new value after sync", 0, 5'h05, 5'h03, 1);

      // R3 no lock without hint
      @(negedge clk); wfi = 1'b1;
      @(negedge clk); wfi = 1'b0;
      rchk("R3 no lock hint 0", 1, 1);

      // R11 write on the locking edge
      wr(0, 32'h001);
      @(negedge clk);
      addr = AW'(0); wdata = 32'h1F1; we = 1'b1; wfi = 1'b1;
      @(negedge clk);
      we = 1'b0; wfi = 1'b0;
      rchk("R11 write accepted", 0, 32'h1F1);
      rchk("R3 ctrl_wen low", 1, 0);
      wr(0, 32'h000);
      rchk("R3 write ignored", 0, 32'h1F1);

      // R4 unlock
      @(negedge clk); active = 1'b1;
      @(negedge clk); active = 1'b0;
      rchk("R4 unlocked", 1, 1);
      wr(0, 32'h021);
      rchk("R4 write accepted", 0, 32'h021);
      // R4 lock beats unlock in same cycle
      @(negedge clk); wfi = 1'b1; active = 1'b1;
      @(negedge clk); wfi = 1'b0; active = 1'b0;
      rchk("R4 lock wins", 1, 0);
      @(negedge clk); active = 1'b1;
      @(negedge clk); active = 1'b0;
      rchk("R4 unlocked again", 1, 1);

      // R6 sticky write-enables
      wr(3, 32'hFFFF_FFFE);
      rchk("R6 wake_wen cleared", 3, 0);
      wr(2, 32'h1C);
      rchk("R6 wake_en frozen", 2, 32'h3);
      wr(3, 32'h1);
      rchk("R6 wake_wen sticky", 3, 0);
      wr(4, 32'h0);
      rchk("R6 rst_en still writable", 4, 0);
      wr(5, 32'h0);
      rchk("R6 rst_wen cleared", 5, 0);
      wr(4, 32'h1);
      rchk("R6 rst_en frozen", 4, 0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule